// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register Model

This block is a synchronous, cycle-level model of a parallel-in, serial-out shift register that is eight stages deep by default. Every control input is sampled on a fast system clock `clk`. An active-low load input copies a parallel word into every stage, and it does so on each system cycle for as long as it stays low. When load is high, the stages shift one place toward the last stage on every rising edge of an effective shift clock. That clock is the OR of two interchangeable inputs, `shift_clk` and `inhibit`. The last stage drives `dout`, and `dout_n` carries its complement.

The design has three parts. An edge-tracking state machine, with states `TRK_LOW` and `TRK_HIGH`, turns the OR of the two clock inputs into a single-cycle `rise` pulse. It moves `TRK_LOW -> TRK_HIGH` when the OR goes high and `TRK_HIGH -> TRK_LOW` when the OR goes low. A phase state machine, with states `PH_LOAD` and `PH_RUN`, records whether load was asserted in the previous cycle. It moves `PH_RUN -> PH_LOAD` when `load_n` goes low and `PH_LOAD -> PH_RUN` when `load_n` goes high. From its state it selects one operation per cycle: `OP_LOAD`, `OP_SHIFT` or `OP_HOLD`. A generated chain of stage flops then applies that operation.

Parameter `RESET_EN` (default 0) selects whether `rst` acts. With the default, the contents are unknown until the first load.

Top module: `piso_shift_model`

## Requirements
- R1: While `load_n` is low, each system cycle loads `pdata` into the stages, with `pdata[i]` going into stage i. One cycle later `dout` equals `pdata[WIDTH-1]`, whatever the levels of `shift_clk`, `inhibit` and `sin`.
- R2: With `load_n` high and `inhibit` low, a low-to-high change on `shift_clk` shifts once. `sin` enters stage 0 and stage i takes stage i-1. `dout` shows the new last stage one cycle later.
- R3: With `load_n` high and `shift_clk` low, a low-to-high change on `inhibit` shifts exactly as R2 does.
- R4: Each rising edge of (`shift_clk` OR `inhibit`) causes exactly one shift. While that OR is held high the register holds, and a falling edge does not shift.
- R5: While `inhibit` is high, a rising `shift_clk` does not shift, and the reverse is also true.
- R6: `dout_n` is always the complement of `dout`.
- R7: If `load_n` was low in the previous cycle and the effective clock rises in the cycle where `load_n` is high, that cycle performs a load of `pdata` and not a shift.
- R8: With `RESET_EN`=1, `rst` high clears every stage to 0 on the next clock. An effective clock that is already high when `rst` is released does not cause a shift.
- R9: The content of the last stage is discarded on a shift. After WIDTH shifts, the register holds only bits that came in through `sin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous clear; acts only when RESET_EN=1 |
| load_n | input | 1 | Active-low, level-sensitive parallel load |
| shift_clk | input | 1 | Shift clock input, ORed with inhibit |
| inhibit | input | 1 | Clock inhibit input, ORed with shift_clk |
| sin | input | 1 | Serial data into stage 0 |
| pdata | input | WIDTH | Parallel data; bit i feeds stage i |
| dout | output | 1 | Last stage |
| dout_n | output | 1 | Complement of the last stage |

## Verification
The bench sweeps all 256 parallel words. Each word is loaded and then shifted out completely, alternating between the two clock inputs so that both paths are exercised. Between shifts it holds the effective clock high and then drops it. A design that also shifted on a held level or on a falling edge would drift ahead of the expected serial stream.

Directed cases cover three corner cases. The first raises `shift_clk` while `inhibit` is already high; a design that detected edges per input and not on the OR would shift there. The second raises the effective clock in the very cycle that load is released; a design that let the shift win would show stage 6 instead of the new word's top bit. The third releases reset while the effective clock is high; a tracker that came out of reset in the low state would insert a spurious shift, and that shift shows up after seven real ones.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } trk_state_t;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_LOAD = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_t;

endpackage

// File: rtl/piso_edge_fsm.sv
module piso_edge_fsm
    import piso_pkg::*;
#(
    parameter bit RESET_EN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_clk,
    input  logic inhibit,
    output logic rise
);

    logic       eff;
    trk_state_t st;
    trk_state_t st_nx;

    assign eff = shift_clk | inhibit;

    // Next state: follow the level of the effective clock
    always_comb begin
        unique case (st)
            TRK_LOW:  st_nx = eff ? TRK_HIGH : TRK_LOW;
            TRK_HIGH: st_nx = eff ? TRK_HIGH : TRK_LOW;
            default:  st_nx = TRK_HIGH;
        endcase
    end

    // State register; reset treats the clock as already high
    always_ff @(posedge clk) begin
        if (RESET_EN && rst) begin
            st <= TRK_HIGH;
        end else begin
            st <= st_nx;
        end
    end

    // Output: one pulse when leaving TRK_LOW on a high level
    always_comb begin
        unique case (st)
            TRK_LOW:  rise = eff;
            TRK_HIGH: rise = 1'b0;
            default:  rise = 1'b0;
        endcase
    end

    // R4: a rising edge yields exactly one pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/piso_mode_ctl.sv
module piso_mode_ctl
    import piso_pkg::*;
#(
    parameter bit RESET_EN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load_n,
    input  logic rise,
    output op_t  op
);

    phase_t st;
    phase_t st_nx;

    always_comb begin
        unique case (st)
            PH_RUN:  st_nx = load_n ? PH_RUN : PH_LOAD;
            PH_LOAD: st_nx = load_n ? PH_RUN : PH_LOAD;
            default: st_nx = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (RESET_EN && rst) begin
            st <= PH_RUN;
        end else begin
            st <= st_nx;
        end
    end

    // Operation select: load level first, then load-release priority
    always_comb begin
        unique case (st)
            PH_LOAD: begin
                if (!load_n)   op = OP_LOAD;
                else if (rise) op = OP_LOAD;
                else           op = OP_HOLD;
            end
            PH_RUN: begin
                if (!load_n)   op = OP_LOAD;
                else if (rise) op = OP_SHIFT;
                else           op = OP_HOLD;
            end
            default: op = OP_HOLD;
        endcase
    end

    // R2: a shift needs a clock edge
    a_r2_shift_needs_edge: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |-> rise);

endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
    import piso_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit RESET_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  op_t              op,
    input  logic             sin,
    input  logic [WIDTH-1:0] pdata,
    output logic [WIDTH-1:0] stq
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic bit_q;
        logic shift_src;

        if (i == 0) begin : g_head
            assign shift_src = sin;
        end else begin : g_body
            assign shift_src = stq[i-1];
        end

        always_ff @(posedge clk) begin
            if (RESET_EN && rst) begin
                bit_q <= 1'b0;
            end else begin
                unique case (op)
                    OP_LOAD:  bit_q <= pdata[i];
                    OP_SHIFT: bit_q <= shift_src;
                    default:  bit_q <= bit_q;
                endcase
            end
        end

        assign stq[i] = bit_q;
    end

endmodule

// File: rtl/piso_shift_model.sv
module piso_shift_model
    import piso_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit RESET_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             shift_clk,
    input  logic             inhibit,
    input  logic             sin,
    input  logic [WIDTH-1:0] pdata,
    output logic             dout,
    output logic             dout_n
);

    localparam int LAST = WIDTH - 1;
    localparam int PREV = (WIDTH > 1) ? WIDTH - 2 : 0;

    logic             rise;
    op_t              op;
    logic [WIDTH-1:0] stq;

    piso_edge_fsm #(.RESET_EN(RESET_EN)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .shift_clk (shift_clk),
        .inhibit   (inhibit),
        .rise      (rise)
    );

    piso_mode_ctl #(.RESET_EN(RESET_EN)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .load_n (load_n),
        .rise   (rise),
        .op     (op)
    );

    piso_stage_chain #(.WIDTH(WIDTH), .RESET_EN(RESET_EN)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .sin   (sin),
        .pdata (pdata),
        .stq   (stq)
    );

    assign dout   = stq[LAST];
    assign dout_n = ~stq[LAST];

    // R1: a low load level shows the top data bit next cycle
    a_r1_load_level: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> dout == $past(pdata[LAST]));

    // R2: a shift moves the previous stage to the output
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && rise) |=> dout == $past(stq[PREV]));

    // R4: no edge means the contents hold
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n && !rise) |=> $stable(stq));

    // R7: releasing load on a clock edge still loads
    a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
        (load_n && !$past(load_n) && rise) |=> dout == $past(pdata[LAST]));

    // R8: the clear empties every stage
    a_r8_clear: assert property (@(posedge clk)
        (RESET_EN && rst) |=> stq == '0);

endmodule

// File: tb/piso_shift_model_test.sv
`timescale 1ns/1ps
module piso_shift_model_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic       shift_clk = 1'b0;
    logic       inhibit = 1'b0;
    logic       sin = 1'b0;
    logic [7:0] pdata = 8'h00;
    logic       dout;
    logic       dout_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    piso_shift_model #(.WIDTH(8), .RESET_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .load_n(load_n), .shift_clk(shift_clk),
        .inhibit(inhibit), .sin(sin), .pdata(pdata),
        .dout(dout), .dout_n(dout_n)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string req);
        n_cmp++;
        if (dout !== exp || dout_n !== ~exp) begin
            n_bad++;
            $display("FAIL %s: dout=%b dout_n=%b expected %b/%b",
                     req, dout, dout_n, exp, ~exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m;
        logic [7:0] sbits;
        @(negedge clk);
        cyc();
        cyc();
        chk(1'b0, "R8 reset state");
        rst = 1'b0;
        cyc();

        // Sweep every parallel word, shift it out through one clock input
        for (int p = 0; p < 256; p++) begin
            logic [7:0] pat;
            bit use_inh;
            pat = p[7:0];
            use_inh = pat[0];
            load_n = 1'b0; pdata = pat;
            shift_clk = pat[1]; inhibit = pat[2]; sin = pat[3];
            cyc();
            chk(pat[7], "R1 load");
            shift_clk = ~pat[1]; sin = ~pat[3];
            cyc();
            chk(pat[7], "R1 load ignores clocks");
            load_n = 1'b1; shift_clk = 1'b0; inhibit = 1'b0;
            cyc();
            chk(pat[7], "R4 release low clock");
            m = pat;
            sbits = pat ^ 8'hA5;
            for (int k = 0; k < 8; k++) begin
                sin = sbits[k];
                if (use_inh) inhibit = 1'b1; else shift_clk = 1'b1;
                cyc();
                m = {m[6:0], sbits[k]};
                if (k == 7) chk(m[7], "R9 all serial");
                else if (use_inh) chk(m[7], "R3 inhibit edge");
                else chk(m[7], "R2 clock edge");
                sin = ~sbits[k];
                cyc();
                chk(m[7], "R4 held high");
                inhibit = 1'b0; shift_clk = 1'b0;
                cyc();
                chk(m[7], "R4 falling edge");
            end
            if (dout_n !== ~dout) begin
                n_bad++;
                $display("FAIL R6: dout=%b dout_n=%b expected complement", dout, dout_n);
            end
            n_cmp++;
        end

        // R5: shift_clk rising while inhibit high does nothing
        load_n = 1'b0; pdata = 8'h80; inhibit = 1'b1; shift_clk = 1'b0; sin = 1'b0;
        cyc();
        chk(1'b1, "R5 setup");
        load_n = 1'b1;
        cyc();
        chk(1'b1, "R5 release");
        shift_clk = 1'b1;
        cyc();
        chk(1'b1, "R5 masked edge");
        shift_clk = 1'b0;
        cyc();
        inhibit = 1'b0;
        cyc();
        chk(1'b1, "R5 inhibit falls");
        shift_clk = 1'b1;
        cyc();
        chk(1'b0, "R5 real edge");
        shift_clk = 1'b0;
        cyc();

        // R7: load released on the same cycle as a clock edge
        load_n = 1'b0; pdata = 8'h00;
        cyc();
        chk(1'b0, "R7 setup");
        load_n = 1'b1; pdata = 8'h80; shift_clk = 1'b1;
        cyc();
        chk(1'b1, "R7 load wins");
        pdata = 8'h00;
        cyc();
        chk(1'b1, "R7 held");
        shift_clk = 1'b0;
        cyc();
        shift_clk = 1'b1;
        cyc();
        chk(1'b0, "R7 next shift");
        shift_clk = 1'b0;
        cyc();

        // R8: clear, release with clock high, no spurious shift
        load_n = 1'b0; pdata = 8'hFF;
        cyc();
        load_n = 1'b1;
        cyc();
        rst = 1'b1; shift_clk = 1'b1; sin = 1'b1;
        cyc();
        chk(1'b0, "R8 clear");
        rst = 1'b0;
        cyc();
        chk(1'b0, "R8 release high");
        shift_clk = 1'b0;
        cyc();
        for (int k = 0; k < 7; k++) begin
            shift_clk = 1'b1;
            cyc();
            shift_clk = 1'b0;
            cyc();
        end
        chk(1'b0, "R8 seven shifts");
        shift_clk = 1'b1;
        cyc();
        chk(1'b1, "R8 eighth shift");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule